// File: doc/BRIEF.md
# Bicubic Resize Coefficient Generator

This block turns one phase weight of a two-pixel blend into the four signed filter taps that a resampling filter applies to the source pixels at relative positions -1, 0, +1 and +2. A weight of 512 selects pixel 0 fully, 256 blends pixels 0 and 1 equally, and 0 selects pixel 1 fully. A small sharpness setting picks the filter character. Setting 0 behaves like nearest-neighbour sampling, setting 1 behaves like a linear blend, and settings 2 to 32 evaluate a cubic convolution kernel whose free parameter grows more negative with the setting.

A request carries the weight, the sharpness and a source-advance offset. It is accepted with a valid/ready handshake. The cubic taps are computed in signed 15.16 fixed point on a single shared multiplier over several cycles. The result leaves as two coefficient words on consecutive cycles. The first word holds taps 0 and 1. The second holds taps 2 and 3 together with the offset. A table loader sits upstream and supplies the weight sequence. The filter that consumes the words sits downstream.

Top module: `bicoef_gen`

## Requirements
- R1: A weight above 512 is treated as 512.
- R2: With sharpness 0, the clamped weight snaps to 512 when it is 256 or more and to 0 otherwise. The taps are then (0, w, 512-w, 0).
- R3: With sharpness 1, the taps are (0, w, 512-w, 0), using the clamped weight w unchanged.
- R4: With sharpness s from 2 to 32, the kernel parameter is a = -s/8, stored as the 15.16 value -8192*s. Let v = 512 - w. Taps 0 to 3 are the kernel evaluated at x = (512+v)/512, v/512, (512-v)/512 and (1024-v)/512, where the x values are written with 9 fraction bits. The kernel is (a+2)x^3 - (a+3)x^2 + 1 for x <= 1 and a(x^3 - 5x^2 + 8x - 4) for 1 < x <= 2. Every fixed-point product is the full 64-bit product divided by 65536, truncated toward zero.
- R5: Each cubic tap is (32768 + 512*k) / 65536, truncated toward zero, where k is the 15.16 kernel value. The result is then saturated to -1024..1023.
- R6: A sharpness above 32 behaves exactly as 32.
- R7: Each accepted request produces exactly two words on consecutive cycles with out_valid high. The first word has out_last low and holds tap 0 in bits [10:0] and tap 1 in bits [21:11]. The second word has out_last high and holds tap 2 in bits [10:0], tap 3 in bits [21:11] and the offset in bits [31:22]. Taps are 11-bit two's complement. out_valid is low in the cycle after the second word.
- R8: in_ready is high only while the block is idle. After a request is accepted, in_ready stays low until the second word has been emitted.
- R9: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request accepted on valid and ready |
| in_weight | input | 11 | Phase weight, 512 means all of pixel 0 |
| in_sharp | input | 6 | Sharpness setting |
| in_offset | input | 10 | Source-advance offset, copied into the second word |
| out_valid | output | 1 | Coefficient word present |
| out_last | output | 1 | High on the second word of a pair |
| out_word | output | 32 | Packed coefficient word |

## Verification
Directed vectors cover weights of 0, 255, 256, 512 and values above 512, paired with sharpness 0, 1, 2, 8, 32 and settings above 32. These vectors separate the snapping rule, the linear rule, the weight clamp and the sharpness clamp. Cubic settings at weight 512 and 0 sit on the segment boundary x = 1 of the kernel. Intermediate weights exercise both kernel segments and the rounding of negative taps toward +infinity. Several hundred seeded random requests mix all modes and offsets. They also check the framing of each word pair and that in_ready is withheld while a pair is being produced.

// File: rtl/bicoef_pkg.sv
package bicoef_pkg;

  localparam int FX_FRAC = 16;
  localparam int FX_ONE  = 1 << FX_FRAC;

  typedef logic signed [31:0] fx_t;

  // 15.16 product: full 64-bit product, divided by 2^16 toward zero
  function automatic fx_t fx_mul(fx_t a, fx_t b);
    logic signed [63:0] p;
    logic signed [63:0] q;
    p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    if (p[63]) p = p + 64'sd65535;
    q = p >>> FX_FRAC;
    return q[31:0];
  endfunction

  // scale by 512, add one half, truncate toward zero (no saturation)
  function automatic fx_t fx_to_tap(fx_t k);
    fx_t v;
    v = (k <<< 9) + 32'sd32768;
    if (v[31]) v = v + 32'sd65535;
    return v >>> FX_FRAC;
  endfunction

endpackage

// File: rtl/bicoef_rst_sync.sv
module bicoef_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_s = sync_q;
endmodule

// File: rtl/bicoef_kernel.sv
module bicoef_kernel
  import bicoef_pkg::*;
#(
  parameter int TAP_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  fx_t              a_fx,
  input  fx_t              x_fx,
  output logic             done,
  output logic [TAP_W-1:0] tap
);
  localparam int TMAX = (1 << (TAP_W - 1)) - 1;
  localparam int TMIN = -(1 << (TAP_W - 1));

  typedef enum logic [2:0] {K_IDLE, K_SQ, K_CU, K_TERM, K_TAIL} kst_t;

  kst_t st_q, st_d;
  fx_t  x_q, a_q, x2_q, x3_q, t1_q;
  logic done_q;
  logic [TAP_W-1:0] tap_q;

  fx_t  mul_a, mul_b, prod, kval, tap_full;
  logic near, ld_en, x2_en, x3_en, t1_en, fin_en;

  assign near = (x_q <= fx_t'(FX_ONE));

  // shared multiplier operand selection
  always_comb begin
    mul_a = x_q;
    mul_b = x_q;
    unique case (st_q)
      K_CU:   mul_b = x2_q;
      K_TERM: begin
        if (near) begin
          mul_a = a_q + fx_t'(2 * FX_ONE);
          mul_b = x3_q;
        end else begin
          mul_a = a_q;
          mul_b = x3_q - 5 * x2_q + 8 * x_q - fx_t'(4 * FX_ONE);
        end
      end
      K_TAIL: begin
        mul_a = a_q + fx_t'(3 * FX_ONE);
        mul_b = x2_q;
      end
      default: ;
    endcase
  end

  assign prod     = fx_mul(mul_a, mul_b);
  assign kval     = (st_q == K_TAIL) ? (t1_q - prod + fx_t'(FX_ONE)) : prod;
  assign tap_full = fx_to_tap(kval);

  always_comb begin
    st_d   = st_q;
    ld_en  = 1'b0;
    x2_en  = 1'b0;
    x3_en  = 1'b0;
    t1_en  = 1'b0;
    fin_en = 1'b0;
    unique case (st_q)
      K_IDLE: if (start) begin ld_en = 1'b1; st_d = K_SQ; end
      K_SQ:   begin x2_en = 1'b1; st_d = K_CU; end
      K_CU:   begin x3_en = 1'b1; st_d = K_TERM; end
      K_TERM: begin
        if (near) begin t1_en = 1'b1; st_d = K_TAIL; end
        else      begin fin_en = 1'b1; st_d = K_IDLE; end
      end
      K_TAIL: begin fin_en = 1'b1; st_d = K_IDLE; end
      default: st_d = K_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= K_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin_en;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en) begin
      x_q <= x_fx;
      a_q <= a_fx;
    end
    if (x2_en) x2_q <= prod;
    if (x3_en) x3_q <= prod;
    if (t1_en) t1_q <= prod;
    if (fin_en) begin
      if (tap_full > fx_t'(TMAX))      tap_q <= TAP_W'(TMAX);
      else if (tap_full < fx_t'(TMIN)) tap_q <= TAP_W'(TMIN);
      else                             tap_q <= tap_full[TAP_W-1:0];
    end
  end

  assign done = done_q;
  assign tap  = tap_q;

  // R4: one result pulse per evaluation
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R4: a square is never negative
  assert_square_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == K_CU) |-> !x2_q[31]);
endmodule

// File: rtl/bicoef_pack.sv
module bicoef_pack #(
  parameter int TAP_W = 11,
  parameter int OFF_W = 10
) (
  input  logic [4*TAP_W-1:0]       taps,
  input  logic [OFF_W-1:0]         offset,
  input  logic                     second,
  output logic [2*TAP_W+OFF_W-1:0] word
);
  logic [TAP_W-1:0] lo, hi;

  assign lo   = second ? taps[2*TAP_W +: TAP_W] : taps[0 +: TAP_W];
  assign hi   = second ? taps[3*TAP_W +: TAP_W] : taps[TAP_W +: TAP_W];
  assign word = {(second ? offset : {OFF_W{1'b0}}), hi, lo};
endmodule

// File: rtl/bicoef_gen.sv
module bicoef_gen
  import bicoef_pkg::*;
#(
  parameter int UNITY     = 512,
  parameter int WEIGHT_W  = 11,
  parameter int SHARP_W   = 6,
  parameter int SHARP_MAX = 32,
  parameter int OFF_W     = 10,
  parameter int TAP_W     = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [WEIGHT_W-1:0]      in_weight,
  input  logic [SHARP_W-1:0]       in_sharp,
  input  logic [OFF_W-1:0]         in_offset,
  output logic                     out_valid,
  output logic                     out_last,
  output logic [2*TAP_W+OFF_W-1:0] out_word
);
  localparam int WQ_W    = $clog2(UNITY) + 1;
  localparam int NX_W    = $clog2(UNITY) + 2;
  localparam int X_SH    = FX_FRAC - $clog2(UNITY);
  localparam int STEP_SH = FX_FRAC - 3;
  localparam int NTAP    = 4;

  typedef enum logic [2:0] {T_IDLE, T_START, T_WAIT, T_EMIT0, T_EMIT1} tst_t;

  logic rst_n_s;
  bicoef_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  tst_t st_q, st_d;
  logic [WQ_W-1:0]    w_q, w_cl, w_eff;
  logic [SHARP_W-1:0] sh_q, sh_cl;
  logic [OFF_W-1:0]   off_q;
  logic [1:0]         idx_q, idx_d;
  logic [TAP_W-1:0]   taps_q [NTAP];
  logic [4*TAP_W-1:0] taps_flat;
  logic cap_en, idx_en, kstart, kdone, bilin_in;
  logic [TAP_W-1:0] ktap;
  logic [NX_W-1:0]  wv, n_sel;
  fx_t a_fx, x_fx;

  // request conditioning
  assign w_cl     = (in_weight > WEIGHT_W'(UNITY)) ? WQ_W'(UNITY) : in_weight[WQ_W-1:0];
  assign sh_cl    = (in_sharp > SHARP_W'(SHARP_MAX)) ? SHARP_W'(SHARP_MAX) : in_sharp;
  assign bilin_in = (sh_cl < SHARP_W'(2));
  assign w_eff    = (sh_cl == '0) ? ((w_cl >= WQ_W'(UNITY / 2)) ? WQ_W'(UNITY) : '0) : w_cl;

  // kernel operands for the tap being evaluated
  assign wv = NX_W'(UNITY) - NX_W'(w_q);
  always_comb begin
    unique case (idx_q)
      2'd0:    n_sel = NX_W'(UNITY) + wv;
      2'd1:    n_sel = wv;
      2'd2:    n_sel = NX_W'(UNITY) - wv;
      default: n_sel = NX_W'(2 * UNITY) - wv;
    endcase
  end
  assign x_fx = fx_t'({{(32 - NX_W){1'b0}}, n_sel}) <<< X_SH;
  assign a_fx = -(fx_t'({{(32 - SHARP_W){1'b0}}, sh_q}) <<< STEP_SH);

  bicoef_kernel #(.TAP_W(TAP_W)) u_kernel (
    .clk(clk), .rst_n(rst_n_s), .start(kstart),
    .a_fx(a_fx), .x_fx(x_fx), .done(kdone), .tap(ktap)
  );

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    cap_en = 1'b0;
    idx_en = 1'b0;
    kstart = 1'b0;
    unique case (st_q)
      T_IDLE: if (in_valid) begin
        cap_en = 1'b1;
        idx_en = 1'b1;
        idx_d  = 2'd0;
        st_d   = bilin_in ? T_EMIT0 : T_START;
      end
      T_START: begin kstart = 1'b1; st_d = T_WAIT; end
      T_WAIT: if (kdone) begin
        if (idx_q == 2'd3) st_d = T_EMIT0;
        else begin
          idx_en = 1'b1;
          idx_d  = idx_q + 2'd1;
          st_d   = T_START;
        end
      end
      T_EMIT0: st_d = T_EMIT1;
      T_EMIT1: st_d = T_IDLE;
      default: st_d = T_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) st_q <= T_IDLE;
    else          st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      w_q   <= w_eff;
      sh_q  <= sh_cl;
      off_q <= in_offset;
    end
    if (idx_en) idx_q <= idx_d;
  end

  generate
    for (genvar i = 0; i < NTAP; i++) begin : g_tap
      logic we_direct, we_kernel;
      logic [TAP_W-1:0] direct_val;
      assign we_direct = cap_en && bilin_in;
      assign we_kernel = (st_q == T_WAIT) && kdone && (idx_q == 2'(i));
      if (i == 1) begin : g_mid0
        assign direct_val = TAP_W'(w_eff);
      end else if (i == 2) begin : g_mid1
        assign direct_val = TAP_W'(UNITY) - TAP_W'(w_eff);
      end else begin : g_edge
        assign direct_val = '0;
      end
      always_ff @(posedge clk) begin
        if (we_direct)      taps_q[i] <= direct_val;
        else if (we_kernel) taps_q[i] <= ktap;
      end
      assign taps_flat[i*TAP_W +: TAP_W] = taps_q[i];
    end
  endgenerate

  bicoef_pack #(.TAP_W(TAP_W), .OFF_W(OFF_W)) u_pack (
    .taps(taps_flat), .offset(off_q), .second(st_q == T_EMIT1), .word(out_word)
  );

  assign in_ready  = (st_q == T_IDLE);
  assign out_valid = (st_q == T_EMIT0) || (st_q == T_EMIT1);
  assign out_last  = (st_q == T_EMIT1);

  // R1: stored weight never exceeds unity
  assert_weight_clamp_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_q != T_IDLE) |-> (w_q <= WQ_W'(UNITY)));
  // R2: snapped weight is either end point
  assert_snap_ends_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid && sh_q == '0) |-> (taps_q[1] == '0 || taps_q[1] == TAP_W'(UNITY)));
  // R3: inner taps of the linear modes sum to unity, outer taps zero
  assert_linear_sum_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid && sh_q < SHARP_W'(2)) |->
      (TAP_W'(taps_q[1] + taps_q[2]) == TAP_W'(UNITY) && taps_q[0] == '0 && taps_q[3] == '0));
  // R6: stored sharpness is within range
  assert_sharp_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_q != T_IDLE) |-> (sh_q <= SHARP_W'(SHARP_MAX)));
  // R7: first word is followed by the second, then a gap
  assert_pair_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid && !out_last) |=> (out_valid && out_last));
  assert_gap_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    out_last |=> !out_valid);
  // R8: acceptance drops ready
  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_valid && in_ready) |=> !in_ready);
endmodule

// File: tb/bicoef_gen_bench.sv
module bicoef_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [10:0] in_weight = '0;
  logic [5:0]  in_sharp = '0;
  logic [9:0]  in_offset = '0;
  logic out_valid, out_last;
  logic [31:0] out_word;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bicoef_gen u_bicoef_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_weight(in_weight), .in_sharp(in_sharp), .in_offset(in_offset),
    .out_valid(out_valid), .out_last(out_last), .out_word(out_word)
  );

  function automatic longint fm(longint a, longint b);
    return (a * b) / 65536;
  endfunction

  function automatic longint kern(longint a, longint x);
    longint x2, x3;
    x2 = fm(x, x);
    x3 = fm(x, x2);
    if (x <= 65536) return fm(a + 131072, x3) - fm(a + 196608, x2) + 65536;
    else if (x <= 131072) return fm(a, x3 - 5 * x2 + 8 * x - 262144);
    return 0;
  endfunction

  function automatic longint cubic_tap(longint a, longint n);
    longint v;
    v = (32768 + 512 * kern(a, n * 128)) / 65536;
    if (v > 1023) v = 1023;
    if (v < -1024) v = -1024;
    return v;
  endfunction

  task automatic ref_taps(input int wt, input int sh, output longint t[4]);
    int w, s, v;
    longint a;
    w = (wt > 512) ? 512 : wt;
    s = (sh > 32) ? 32 : sh;
    if (s < 2) begin
      if (s == 0) w = (w >= 256) ? 512 : 0;
      t[0] = 0; t[1] = w; t[2] = 512 - w; t[3] = 0;
    end else begin
      a = -8192 * s;
      v = 512 - w;
      t[0] = cubic_tap(a, 512 + v);
      t[1] = cubic_tap(a, v);
      t[2] = cubic_tap(a, 512 - v);
      t[3] = cubic_tap(a, 1024 - v);
    end
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string tagof(int sh, int wt);
    if (sh > 32) return "R6";
    if (sh == 0) return (wt > 512) ? "R1/R2" : "R2";
    if (sh == 1) return (wt > 512) ? "R1/R3" : "R3";
    return (wt > 512) ? "R1/R4/R5" : "R4/R5";
  endfunction

  task automatic run_one(input int wt, input int sh, input int off);
    longint t[4];
    longint got;
    string tg;
    int wait_cnt;
    ref_taps(wt, sh, t);
    tg = tagof(sh, wt);
    @(negedge clk);
    wait_cnt = 0;
    while (!in_ready && wait_cnt < 100) begin @(negedge clk); wait_cnt++; end
    in_weight = 11'(wt); in_sharp = 6'(sh); in_offset = 10'(off);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R8 ready low after accept", longint'(in_ready), 0);
    wait_cnt = 0;
    while (!out_valid && wait_cnt < 100) begin
      chk(in_ready == 1'b0, "R8 ready low while busy", longint'(in_ready), 0);
      @(negedge clk); wait_cnt++;
    end
    chk(out_valid == 1'b1, "R7 first word present", longint'(out_valid), 1);
    chk(out_last == 1'b0, "R7 first word last flag", longint'(out_last), 0);
    got = longint'($signed(out_word[10:0]));
    chk(got == t[0], {tg, " tap0"}, got, t[0]);
    got = longint'($signed(out_word[21:11]));
    chk(got == t[1], {tg, " tap1"}, got, t[1]);
    @(negedge clk);
    chk(out_valid && out_last, "R7 second word framing", longint'({out_valid, out_last}), 3);
    got = longint'($signed(out_word[10:0]));
    chk(got == t[2], {tg, " tap2"}, got, t[2]);
    got = longint'($signed(out_word[21:11]));
    chk(got == t[3], {tg, " tap3"}, got, t[3]);
    chk(out_word[31:22] == 10'(off), "R7 offset field", longint'(out_word[31:22]), off);
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 gap after pair", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R8 ready after pair", longint'(in_ready), 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_0042);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 out_valid after reset", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R9 in_ready after reset", longint'(in_ready), 1);

    // directed corners
    for (int s = 0; s < 7; s++) begin
      int sh;
      case (s)
        0: sh = 0; 1: sh = 1; 2: sh = 2; 3: sh = 8;
        4: sh = 32; 5: sh = 40; default: sh = 63;
      endcase
      for (int k = 0; k < 7; k++) begin
        int wt;
        case (k)
          0: wt = 0; 1: wt = 255; 2: wt = 256; 3: wt = 512;
          4: wt = 513; 5: wt = 2047; default: wt = 100;
        endcase
        run_one(wt, sh, (s * 7 + k) * 13 % 1024);
      end
    end
    // R6: above-range sharpness equals the top setting
    run_one(300, 33, 1023);
    run_one(300, 32, 0);

    // seeded random mix
    for (int i = 0; i < 300; i++) begin
      int wt, sh, off;
      wt  = ($urandom % 4 == 0) ? int'($urandom % 2048) : int'($urandom % 513);
      sh  = int'($urandom % 64);
      off = int'($urandom % 1024);
      run_one(wt, sh, off);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule